// File: doc/BRIEF.md
# Trigger Line Crossbar with Event Snapshot

This block manages the trigger lines of a modular instrument backplane controller. It senses eight TTL-class backplane trigger lines, two ECL-class backplane trigger lines and one front-panel trigger input. It drives the same eight TTL lines, the two ECL lines and one front-panel trigger output. Every sensed input passes through a two-flop synchronizer. A host then configures through a small register port which synchronized line drives each destination. A host write can also force any destination high on top of an existing route, so software can fire a trigger without tearing down a connection.

Each sensed line can be enabled to raise a processor interrupt on its rising edge. On the first such edge after the pending status was empty, the block captures the level of all eleven sensed lines in one cycle. That snapshot is held until software clears every pending status bit. Later edges only OR into the status.

Line index used throughout: 0 to 7 are TTL lines 0 to 7, 8 and 9 are ECL lines 0 and 1, and 10 is the front-panel line. Index 10 is the front-panel input when it is a source and the front-panel output when it is a destination. Register map (16-bit data): addresses 0 to 10 hold the route of destination d, with bits 3:0 as the source code and bit 4 as the enable. Address 11 is the force mask, address 12 the interrupt enable mask and address 13 the live line levels (read only). Address 14 is the pending status, where writing 1 clears a bit. Address 15 is the snapshot (read only).

Top module: `trig_xbar`

## Requirements
- R1: After reset every data output, every output enable and `irq` are low, and every register reads zero.
- R2: A destination whose route enable is 1 and whose source code c is 0 to 10 drives the level of sensed line c with its output enable high. A level change on an input appears at the routed output on the third rising clock edge after it is set up. Source codes 11 to 15 drive low with the enable high.
- R3: A destination with route enable 0 and force bit 0 has its output enable low and its data output low, whatever its source line does.
- R4: Force bit d set at address 11 drives destination d high with its enable high, ORed with any route on it. The output follows on the second edge after the write.
- R5: Address 13 reads the synchronized level of all eleven sensed lines in bits 10:0, two edges after an input change.
- R6: A rising edge on a sensed line whose bit is set at address 12 sets the same bit at address 14 and raises `irq`. An edge on a line whose enable bit is 0 leaves the status unchanged.
- R7: The first enabled edge while status is all zero loads address 15 with the levels of all lines as sampled alongside that edge. Later edges while any status bit is pending leave the snapshot unchanged.
- R8: Writing address 14 clears exactly the status bits written as 1. `irq` stays high while any bit remains and falls once all are clear.
- R9: An input held high for two clock periods, then low, is always recorded as one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, well above 10 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| ttl_in | input | 8 | Sensed TTL backplane trigger lines |
| ecl_in | input | 2 | Sensed ECL backplane trigger lines |
| fp_in | input | 1 | Front-panel trigger input |
| ttl_out | output | 8 | Drive value for TTL lines |
| ttl_oe | output | 8 | Drive enable for TTL lines |
| ecl_out | output | 2 | Drive value for ECL lines |
| ecl_oe | output | 2 | Drive enable for ECL lines |
| fp_out | output | 1 | Front-panel trigger output value |
| fp_oe | output | 1 | Front-panel trigger output enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |
| irq | output | 1 | Interrupt, high while any status bit is pending |

## Verification
A wrong route selection or a stuck enable shows up at the drive pins three edges after the source line moves. The bench sweeps random routes, force masks and line levels and compares all eleven destinations against a model. A broken synchronizer or edge detector shows as a missing, doubled or misplaced status bit within three edges of a two-cycle pulse. A snapshot that is overwritten, or a clear that hits the wrong bit, shows on the next read of addresses 14 and 15 after a second event.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // register offsets placed after the per-destination route words
  localparam int OFS_MAN  = 0;
  localparam int OFS_IEN  = 1;
  localparam int OFS_LIVE = 2;
  localparam int OFS_STS  = 3;
  localparam int OFS_SNAP = 4;
  localparam int NUM_CTRL = 5;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/trig_route.sv
module trig_route #(
  parameter int NLINE = 11,
  parameter int SELW  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLINE-1:0]      lvl,
  input  logic [NLINE-1:0]      route_en,
  input  logic [NLINE*SELW-1:0] route_sel,
  input  logic [NLINE-1:0]      man,
  output logic [NLINE-1:0]      drv,
  output logic [NLINE-1:0]      oe
);
  logic [NLINE-1:0] drv_n, oe_n;

  for (genvar d = 0; d < NLINE; d++) begin : g_dst
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NLINE; k++) begin
        if (route_sel[d*SELW +: SELW] == SELW'(k)) hit = lvl[k];
      end
      drv_n[d] = man[d] | (route_en[d] & hit);
      oe_n[d]  = man[d] | route_en[d];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv <= '0;
      oe  <= '0;
    end else begin
      drv <= drv_n;
      oe  <= oe_n;
    end
  end
endmodule

// File: rtl/trig_regs.sv
module trig_regs
  import trig_pkg::*;
#(
  parameter int NLINE = 11,
  parameter int SELW  = 4,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic [NLINE-1:0]      lvl,
  input  logic [NLINE-1:0]      rise,
  output logic [NLINE-1:0]      route_en,
  output logic [NLINE*SELW-1:0] route_sel,
  output logic [NLINE-1:0]      man,
  output logic [NLINE-1:0]      ien,
  output logic [NLINE-1:0]      sts,
  output logic [NLINE-1:0]      snap,
  output logic                  irq
);
  localparam logic [AW-1:0] A_MAN  = AW'(NLINE + OFS_MAN);
  localparam logic [AW-1:0] A_IEN  = AW'(NLINE + OFS_IEN);
  localparam logic [AW-1:0] A_LIVE = AW'(NLINE + OFS_LIVE);
  localparam logic [AW-1:0] A_STS  = AW'(NLINE + OFS_STS);
  localparam logic [AW-1:0] A_SNAP = AW'(NLINE + OFS_SNAP);

  logic [SELW:0] rt_q [NLINE];

  for (genvar d = 0; d < NLINE; d++) begin : g_rt
    logic rt_ce;
    assign rt_ce = reg_we && (reg_addr == AW'(d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rt_q[d] <= '0;
      else if (rt_ce) rt_q[d] <= reg_wdata[SELW:0];
    end
    assign route_en[d]               = rt_q[d][SELW];
    assign route_sel[d*SELW +: SELW] = rt_q[d][SELW-1:0];
  end

  logic             man_ce, ien_ce, clr_ce, snap_ce;
  logic [NLINE-1:0] hit, kept, sts_n;

  always_comb begin
    man_ce  = reg_we && (reg_addr == A_MAN);
    ien_ce  = reg_we && (reg_addr == A_IEN);
    clr_ce  = reg_we && (reg_addr == A_STS);
    hit     = rise & ien;
    kept    = clr_ce ? (sts & ~reg_wdata[NLINE-1:0]) : sts;
    sts_n   = kept | hit;
    snap_ce = (kept == '0) && (hit != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man  <= '0;
      ien  <= '0;
      sts  <= '0;
      snap <= '0;
    end else begin
      if (man_ce)  man  <= reg_wdata[NLINE-1:0];
      if (ien_ce)  ien  <= reg_wdata[NLINE-1:0];
      sts <= sts_n;
      if (snap_ce) snap <= lvl;
    end
  end

  assign irq = |sts;

  always_comb begin
    reg_rdata = '0;
    for (int d = 0; d < NLINE; d++) begin
      if (reg_addr == AW'(d)) reg_rdata[SELW:0] = rt_q[d];
    end
    case (reg_addr)
      A_MAN:   reg_rdata[NLINE-1:0] = man;
      A_IEN:   reg_rdata[NLINE-1:0] = ien;
      A_LIVE:  reg_rdata[NLINE-1:0] = lvl;
      A_STS:   reg_rdata[NLINE-1:0] = sts;
      A_SNAP:  reg_rdata[NLINE-1:0] = snap;
      default: ;
    endcase
  end
endmodule

// File: rtl/trig_xbar.sv
module trig_xbar
  import trig_pkg::*;
#(
  parameter int NTTL = 8,
  parameter int NECL = 2,
  parameter int DW   = 16,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTTL-1:0] ttl_in,
  input  logic [NECL-1:0] ecl_in,
  input  logic            fp_in,
  output logic [NTTL-1:0] ttl_out,
  output logic [NTTL-1:0] ttl_oe,
  output logic [NECL-1:0] ecl_out,
  output logic [NECL-1:0] ecl_oe,
  output logic            fp_out,
  output logic            fp_oe,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);
  localparam int NLINE = NTTL + NECL + 1;
  localparam int SELW  = $clog2(NLINE + 1);

  logic [NLINE-1:0]      lvl, rise, route_en, man, ien, sts, snap, drv, oe;
  logic [NLINE*SELW-1:0] route_sel;

  trig_sync #(.W(NLINE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({fp_in, ecl_in, ttl_in}),
    .lvl(lvl), .rise(rise)
  );

  trig_regs #(.NLINE(NLINE), .SELW(SELW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lvl(lvl), .rise(rise),
    .route_en(route_en), .route_sel(route_sel), .man(man), .ien(ien),
    .sts(sts), .snap(snap), .irq(irq)
  );

  trig_route #(.NLINE(NLINE), .SELW(SELW)) u_route (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .route_en(route_en),
    .route_sel(route_sel), .man(man), .drv(drv), .oe(oe)
  );

  assign ttl_out = drv[NTTL-1:0];
  assign ttl_oe  = oe[NTTL-1:0];
  assign ecl_out = drv[NTTL +: NECL];
  assign ecl_oe  = oe[NTTL +: NECL];
  assign fp_out  = drv[NLINE-1];
  assign fp_oe   = oe[NLINE-1];
endmodule

// File: rtl/trig_xbar_chk.sv
module trig_xbar_chk
  import trig_pkg::*;
#(
  parameter int NLINE = 11,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [NLINE-1:0] drv,
  input logic [NLINE-1:0] oe,
  input logic             irq,
  input logic [NLINE-1:0] sts,
  input logic [NLINE-1:0] snap,
  input logic [NLINE-1:0] ien
);
  localparam logic [AW-1:0] A_MAN = AW'(NLINE + OFS_MAN);
  localparam logic [AW-1:0] A_STS = AW'(NLINE + OFS_STS);

  logic clr_wr;
  assign clr_wr = reg_we && (reg_addr == A_STS);

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (drv & ~oe) == '0); // R3

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_MAN) |=> ##1
      ((drv & $past(reg_wdata[NLINE-1:0], 2)) == $past(reg_wdata[NLINE-1:0], 2))); // R4

  AST_STS_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~$past(sts) & ~$past(ien)) == '0); // R6

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> $stable(snap)); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq); // R8
endmodule

bind trig_xbar trig_xbar_chk #(.NLINE(NLINE), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .drv(drv), .oe(oe), .irq(irq), .sts(sts),
  .snap(snap), .ien(ien)
);

// File: tb/trig_xbar_tb.sv
module trig_xbar_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 11;

  logic        clk, rst_n;
  logic [10:0] ln;
  logic [7:0]  ttl_out, ttl_oe;
  logic [1:0]  ecl_out, ecl_oe;
  logic        fp_out, fp_oe, irq;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  int total = 0;
  int bad = 0;

  logic       ren [NL];
  logic [3:0] rsel [NL];
  logic [10:0] mman;

  trig_xbar u_dut (
    .clk(clk), .rst_n(rst_n), .ttl_in(ln[7:0]), .ecl_in(ln[9:8]), .fp_in(ln[10]),
    .ttl_out(ttl_out), .ttl_oe(ttl_oe), .ecl_out(ecl_out), .ecl_oe(ecl_oe),
    .fp_out(fp_out), .fp_oe(fp_oe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_drv(logic [10:0] l);
    logic [10:0] r;
    for (int d = 0; d < NL; d++)
      r[d] = mman[d] | (ren[d] && rsel[d] < 4'd11 && l[rsel[d]]);
    return r;
  endfunction

  function automatic logic [10:0] exp_oe();
    logic [10:0] r;
    for (int d = 0; d < NL; d++) r[d] = mman[d] | ren[d];
    return r;
  endfunction

  function automatic logic [10:0] got_drv();
    return {fp_out, ecl_out, ttl_out};
  endfunction

  function automatic logic [10:0] got_oe();
    return {fp_oe, ecl_oe, ttl_oe};
  endfunction

  task automatic wr(logic [3:0] a, logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(int b);
    @(negedge clk);
    ln[b] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    ln[b] = 1'b0;
    cyc(5);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; ln = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int d = 0; d < NL; d++) begin ren[d] = 1'b0; rsel[d] = '0; end
    mman = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1: reset state
    chk("R1 drive", {5'd0, got_drv()}, 16'd0);
    chk("R1 enable", {5'd0, got_oe()}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v);
      chk("R1 register", v, 16'd0);
    end

    // R3: undriven destination ignores its source
    ln[0] = 1'b1;
    wr(4'd10, 16'h0000);
    cyc(4);
    chk("R3 fp_oe", {15'd0, fp_oe}, 16'd0);
    chk("R3 fp_out", {15'd0, fp_out}, 16'd0);

    // R2: cross-class routes, exact latency (TTL0 to fp_out)
    wr(4'd10, 16'h0010); rsel[10] = 4'd0; ren[10] = 1'b1;
    ln = '0;
    cyc(4);
    @(negedge clk); ln[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 latency early", {15'd0, fp_out}, 16'd0);
    @(posedge clk); @(negedge clk);
    chk("R2 latency third edge", {15'd0, fp_out}, 16'd1);

    // R4: force ORs onto a route
    ln[0] = 1'b0;
    cyc(4);
    wr(4'd11, 16'h0400); mman = 11'h400;
    @(posedge clk); @(negedge clk);
    chk("R4 force", {15'd0, fp_out}, 16'd1);
    wr(4'd11, 16'h0000); mman = '0;

    // R2 R4 R5: random routes, force masks and levels
    for (int it = 0; it < 40; it++) begin
      for (int d = 0; d < NL; d++) begin
        logic [4:0] f;
        f = 5'($urandom);
        ren[d] = f[4]; rsel[d] = f[3:0];
        wr(d[3:0], {11'd0, f});
      end
      mman = (it % 3 == 0) ? 11'($urandom) : 11'd0;
      wr(4'd11, {5'd0, mman});
      @(negedge clk); ln = 11'($urandom);
      cyc(4);
      chk("R2 R4 drive", {5'd0, got_drv()}, {5'd0, exp_drv(ln)});
      chk("R2 R3 enable", {5'd0, got_oe()}, {5'd0, exp_oe()});
      rd(4'd13, v);
      chk("R5 live", v, {5'd0, ln});
    end

    // clear routes and force, prepare interrupt tests
    for (int d = 0; d < NL; d++) begin wr(d[3:0], 16'h0); ren[d] = 1'b0; end
    wr(4'd11, 16'h0); mman = '0;
    ln = '0;
    cyc(4);
    wr(4'd14, 16'h07FF);
    wr(4'd12, 16'h0208);
    ln[0] = 1'b1;
    cyc(4);

    // R6 R7 R9: two-cycle pulse on enabled TTL3
    pulse(3);
    chk("R6 irq", {15'd0, irq}, 16'd1);
    rd(4'd14, v); chk("R9 R6 status", v, 16'h0008);
    rd(4'd15, v); chk("R7 snapshot", v, 16'h0009);

    // R7: second event ORs status, snapshot held
    ln[0] = 1'b0;
    pulse(9);
    rd(4'd14, v); chk("R7 status or", v, 16'h0208);
    rd(4'd15, v); chk("R7 snapshot held", v, 16'h0009);

    // R6: disabled line ignored
    pulse(5);
    rd(4'd14, v); chk("R6 disabled line", v, 16'h0208);

    // R8: selective clear
    wr(4'd14, 16'h0008);
    rd(4'd14, v); chk("R8 partial clear", v, 16'h0200);
    chk("R8 irq stays", {15'd0, irq}, 16'd1);
    wr(4'd14, 16'h0200);
    rd(4'd14, v); chk("R8 full clear", v, 16'h0000);
    chk("R8 irq falls", {15'd0, irq}, 16'd0);

    // R7: fresh capture after clear
    pulse(3);
    rd(4'd15, v); chk("R7 new snapshot", v, 16'h0008);
    chk("R6 irq again", {15'd0, irq}, 16'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule